// File: doc/BRIEF.md
# Split-Load Transmit Word Buffer

This block is the staging buffer that sits in front of a serial word transmitter. It holds up to eight 31-bit words. The host reaches it over a 16-bit bus, so each word arrives in two writes. A low-half strobe captures bits 15:0 into a holding register. A later high-half strobe supplies bits 30:16 and stores the complete word in the next free slot in the same clock edge.

The serializer takes words out in arrival order through a valid/ready pop port. A transmitter-ready output is high only while the buffer holds nothing, so the host can tell when every queued word has been sent. A full flag marks the point at which further loads have no effect. Serialization, parity and line timing belong to other blocks.

Top module: `halfLoadTxFifo`

## Requirements
- R1: A synchronous active-low reset clears every slot, the occupancy and the pending half. After reset, txReady is 1, popValid is 0, bufFull is 0 and popWord is 0.
- R2: loadLow captures busData[15:0] as word bits 15:0. A following loadHigh uses busData[14:0] as word bits 30:16, ignores busData[15], and commits the word. popValid is high in the cycle after the commit edge.
- R3: loadHigh with no captured low half pending is ignored, and no word is stored.
- R4: Repeated loadLow strobes before a loadHigh replace the pending low half, and the most recent one is used.
- R5: When loadLow and loadHigh are both high in one cycle, the cycle acts as a loadLow alone and commits nothing.
- R6: Words leave through popWord in the order in which they were committed.
- R7: With 8 words stored, bufFull is 1. Both strobes are then ignored even if a pop happens in the same cycle, and the stored words are unchanged.
- R8: txReady is 1 exactly when no word is stored. It falls after the first commit and rises after the last stored word is popped.
- R9: popValid is 1 exactly when a word is stored, and popWord shows the oldest stored word. A word leaves only on a cycle where popValid and popReady are both high. While popReady is low, popWord and popValid stay unchanged.
- R10: A pop and a commit in the same cycle leave the occupancy unchanged, and the committed word queues behind the remaining ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| busData | input | 16 | Host half-word bus |
| loadLow | input | 1 | Capture strobe for word bits 15:0 |
| loadHigh | input | 1 | Strobe for word bits 30:16; commits the word |
| popReady | input | 1 | Serializer accepts the offered word |
| popValid | output | 1 | A word is offered on popWord |
| popWord | output | 31 | Oldest stored word |
| txReady | output | 1 | Buffer empty |
| bufFull | output | 1 | All 8 slots occupied |

## Verification
Words are loaded one at a time and drained at once. They are also loaded in a batch of eight and drained later, which checks both the ready flag's edges and the ordering across pointer wrap. Irregular strobe patterns are applied: a high strobe with no pending low half, two low strobes in a row, and both strobes in one cycle. Each pattern gives a different committed word, or no word at all, so a design that mishandles the pending state produces the wrong data. Loads attempted while the buffer is full, and a commit that coincides with a pop, separate "full" from "busy" and show whether the occupancy count handles simultaneous events correctly.

// File: rtl/halfLoadTxFifoPkg.sv
package halfLoadTxFifoPkg;
  // Per-cycle actions decided by the control and carried out by the datapath.
  typedef struct packed {
    logic latchLow;  // capture low half from the bus
    logic commit;    // write assembled word at the write pointer
    logic pop;       // oldest word leaves this edge
  } fifoStrobes_t;
endpackage

// File: rtl/halfLoadTxFifoCtrl.sv
module halfLoadTxFifoCtrl
  import halfLoadTxFifoPkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadLow,
  input  logic             loadHigh,
  input  logic             popReady,
  output fifoStrobes_t     strobes,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic             txReady,
  output logic             popValid,
  output logic             bufFull
);
  logic [CNT_W-1:0] count;
  logic             pending;
  logic             isFull;
  logic             isEmpty;

  assign isFull  = (count == CNT_W'(DEPTH));
  assign isEmpty = (count == '0);

  // A full buffer ignores both strobes; the low strobe wins over the high.
  always_comb begin
    strobes.latchLow = loadLow && !isFull;
    strobes.commit   = loadHigh && !loadLow && pending && !isFull;
    strobes.pop      = popReady && !isEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (strobes.latchLow) begin
      pending <= 1'b1;
    end else if (strobes.commit) begin
      pending <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
    end else if (strobes.commit) begin
      wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
    end else if (strobes.pop) begin
      rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else begin
      unique case ({strobes.commit, strobes.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign txReady  = isEmpty;
  assign popValid = !isEmpty;
  assign bufFull  = isFull;
endmodule

// File: rtl/halfLoadTxFifoData.sv
module halfLoadTxFifoData
  import halfLoadTxFifoPkg::*;
#(
  parameter int WORD_W = 31,
  parameter int LOW_W  = 16,
  parameter int DEPTH  = 8,
  localparam int HIGH_W = WORD_W - LOW_W,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobes_t      strobes,
  input  logic [LOW_W-1:0]  busData,
  input  logic [PTR_W-1:0]  wrPtr,
  input  logic [PTR_W-1:0]  rdPtr,
  output logic [WORD_W-1:0] popWord
);
  logic [LOW_W-1:0]  lowHold;
  logic [WORD_W-1:0] fullWord;
  logic [WORD_W-1:0] slots [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowHold <= '0;
    end else if (strobes.latchLow) begin
      lowHold <= busData;
    end
  end

  assign fullWord = {busData[HIGH_W-1:0], lowHold};

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slots[g] <= '0;
      end else if (strobes.commit && (wrPtr == PTR_W'(g))) begin
        slots[g] <= fullWord;
      end
    end
  end

  assign popWord = slots[rdPtr];
endmodule

// File: rtl/halfLoadTxFifo.sv
module halfLoadTxFifo
  import halfLoadTxFifoPkg::*;
#(
  parameter int WORD_W = 31,
  parameter int LOW_W  = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LOW_W-1:0]  busData,
  input  logic              loadLow,
  input  logic              loadHigh,
  input  logic              popReady,
  output logic              popValid,
  output logic [WORD_W-1:0] popWord,
  output logic              txReady,
  output logic              bufFull
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  fifoStrobes_t     strobes;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  halfLoadTxFifoCtrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .loadLow(loadLow), .loadHigh(loadHigh),
    .popReady(popReady), .strobes(strobes), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .txReady(txReady), .popValid(popValid), .bufFull(bufFull)
  );

  halfLoadTxFifoData #(.WORD_W(WORD_W), .LOW_W(LOW_W), .DEPTH(DEPTH)) data_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busData(busData),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .popWord(popWord)
  );
endmodule

// File: rtl/halfLoadTxFifoChk.sv
module halfLoadTxFifoChk #(
  parameter int WORD_W = 31,
  parameter int LOW_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [LOW_W-1:0]  busData,
  input logic              loadLow,
  input logic              loadHigh,
  input logic              popReady,
  input logic              popValid,
  input logic [WORD_W-1:0] popWord,
  input logic              txReady,
  input logic              bufFull
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rstN |=> (txReady && !popValid && !bufFull));

  // R8
  idle_stays_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txReady && !loadHigh) |=> txReady);

  // R9
  ready_valid_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txReady != popValid));

  // R9
  hold_offer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popValid && !popReady) |=> (popValid && $stable(popWord)));

  // R7
  full_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bufFull && !popReady) |=> (bufFull && $stable(popWord)));

  // R7
  full_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufFull |-> !txReady);
endmodule

bind halfLoadTxFifo halfLoadTxFifoChk #(.WORD_W(WORD_W), .LOW_W(LOW_W)) chk_i (
  .clk(clk), .rstN(rstN), .busData(busData), .loadLow(loadLow),
  .loadHigh(loadHigh), .popReady(popReady), .popValid(popValid),
  .popWord(popWord), .txReady(txReady), .bufFull(bufFull)
);

// File: tb/halfLoadTxFifo_tb_top.sv
module halfLoadTxFifo_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busData = '0;
  logic        loadLow = 1'b0;
  logic        loadHigh = 1'b0;
  logic        popReady = 1'b0;
  logic        popValid;
  logic [30:0] popWord;
  logic        txReady;
  logic        bufFull;

  int compared = 0;
  int mismatched = 0;
  bit pend = 1'b0;
  logic [30:0] expQ[$];

  always #2 clk = ~clk;

  halfLoadTxFifo dut_i (
    .clk(clk), .rstN(rstN), .busData(busData), .loadLow(loadLow),
    .loadHigh(loadHigh), .popReady(popReady), .popValid(popValid),
    .popWord(popWord), .txReady(txReady), .bufFull(bufFull)
  );

  function automatic logic [30:0] mk(input logic [15:0] lo, input logic [15:0] hi);
    return {hi[14:0], lo};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Driver: all strobes change 1 ns after a rising edge.
  task automatic strobeLow(input logic [15:0] d);
    if (expQ.size() < 8) pend = 1'b1;
    busData = d; loadLow = 1'b1;
    tick();
    loadLow = 1'b0;
  endtask

  task automatic strobeHigh(input logic [15:0] d, input logic [15:0] lo);
    if (pend && expQ.size() < 8) begin
      expQ.push_back(mk(lo, d));
      pend = 1'b0;
    end
    busData = d; loadHigh = 1'b1;
    tick();
    loadHigh = 1'b0;
  endtask

  task automatic pushWord(input logic [15:0] lo, input logic [15:0] hi);
    strobeLow(lo);
    strobeHigh(hi, lo);
  endtask

  task automatic drain();
    popReady = 1'b1;
    while (expQ.size() != 0) @(negedge clk);
    tick();
    popReady = 1'b0;
  endtask

  // Monitor: compares each popped word with the scoreboard (R6, R9).
  always @(negedge clk) begin
    if (rstN && popValid && popReady) begin
      if (expQ.size() == 0) begin
        compared++; mismatched++;
        $display("FAIL R9: actual %h expected no word", popWord);
      end else begin
        check("R6 order", {1'b0, popWord}, {1'b0, expQ.pop_front()});
      end
    end
  end

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #400000;
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    check("R1 txReady", 32'(txReady), 32'd1);
    check("R1 popValid", 32'(popValid), 32'd0);
    check("R1 bufFull", 32'(bufFull), 32'd0);
    check("R1 popWord", 32'(popWord), 32'd0);

    // R2 single word, bit 15 of the high half ignored; R8 fall
    pushWord(16'hA5C3, 16'hFFFF);
    check("R8 txReady fell", 32'(txReady), 32'd0);
    check("R2 popValid", 32'(popValid), 32'd1);
    check("R2 popWord", 32'(popWord), 32'(mk(16'hA5C3, 16'hFFFF)));
    drain();
    check("R8 txReady rose", 32'(txReady), 32'd1);

    // R7 fill to capacity, then loads are ignored
    for (int i = 0; i < 8; i++) pushWord(16'(16'h1000 + i), 16'(16'h0100 * i + 3));
    check("R7 bufFull", 32'(bufFull), 32'd1);
    pushWord(16'hDEAD, 16'h0BEE);
    check("R7 still full", 32'(bufFull), 32'd1);
    check("R7 head kept", 32'(popWord), 32'(mk(16'h1000, 16'h0003)));
    drain();  // R6 order checked by monitor
    check("R8 empty after batch", 32'(txReady), 32'd1);

    // R3 high strobe with nothing pending
    strobeHigh(16'h1234, 16'h0000);
    tick();
    check("R3 no commit", 32'(txReady), 32'd1);

    // R4 latest low half wins
    strobeLow(16'h1111);
    strobeLow(16'h2222);
    strobeHigh(16'h3333, 16'h2222);
    check("R4 word", 32'(popWord), 32'(mk(16'h2222, 16'h3333)));
    drain();

    // R5 both strobes at once act as low only
    pend = 1'b1;
    busData = 16'h4455; loadLow = 1'b1; loadHigh = 1'b1;
    tick();
    loadLow = 1'b0; loadHigh = 1'b0;
    check("R5 no commit", 32'(txReady), 32'd1);
    strobeHigh(16'h0066, 16'h4455);
    check("R5 word", 32'(popWord), 32'(mk(16'h4455, 16'h0066)));
    drain();

    // R10 pop and commit in one cycle
    pushWord(16'h0A0A, 16'h0B0B);
    strobeLow(16'h0C0C);
    expQ.push_back(mk(16'h0C0C, 16'h0D0D));
    pend = 1'b0;
    busData = 16'h0D0D; loadHigh = 1'b1; popReady = 1'b1;
    tick();
    loadHigh = 1'b0; popReady = 1'b0;
    check("R10 still occupied", 32'(txReady), 32'd0);
    check("R10 popValid", 32'(popValid), 32'd1);
    check("R10 new head", 32'(popWord), 32'(mk(16'h0C0C, 16'h0D0D)));
    drain();
    check("R10 empty after", 32'(txReady), 32'd1);

    repeat (2) tick();
    finishRun();
  end
endmodule